// File: doc/BRIEF.md
# Configurable External Interrupt Detector

This block turns one asynchronous external interrupt pin into a request flag for the interrupt controller. Two configuration inputs set the mode. One chooses level or transition triggering. The other chooses the active polarity: low or high in level mode, falling or rising edge in transition mode. The pin passes through a two-flop synchroniser. Edges are found by comparing the synchronised sample with the sample one cycle older.

In transition mode, an edge sets the request flag. The flag stays set until the controller acknowledges this source or software clears it. If a new edge arrives in the same cycle as a clear, the edge wins, so no event is lost. In level mode, the flag follows the synchronised pin. Acknowledge and software clear have no effect there, because the pin itself holds the request.

Top module: `ext_irq_detect`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `req_o` is 0 (with the pin held low).
- R2: In transition mode (`trig_edge_i`=1) with `pol_high_i`=1, a 0-to-1 change on `pin_i` sets `req_o`. `req_o` goes high on the third rising clock edge after the pin change. A 1-to-0 change does not set it.
- R3: In transition mode, once `req_o` is set it stays set while neither `ack_i` nor `sw_clr_i` is asserted, whatever the pin does.
- R4: In transition mode, `ack_i` high for one cycle with no new qualifying edge clears `req_o` after that clock edge. A pin held steady afterwards does not set it again.
- R5: In transition mode with `pol_high_i`=0, a 1-to-0 pin change sets `req_o` with the same three-edge latency. A 0-to-1 change does not set it.
- R6: In transition mode, `sw_clr_i` high for one cycle clears `req_o` in the same way as `ack_i`.
- R7: In transition mode, if a qualifying edge is detected in the same cycle as `ack_i` or `sw_clr_i`, `req_o` stays 1.
- R8: In level mode (`trig_edge_i`=0), `req_o` is 1 exactly when the synchronised pin is at the active level (1 when `pol_high_i`=1, 0 when `pol_high_i`=0). The output lags the pin by three clock edges, or by one edge after a mode or polarity change.
- R9: In level mode, `ack_i` and `sw_clr_i` do not lower `req_o` while the pin is at its active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous external interrupt pin |
| trig_edge_i | input | 1 | 1 selects transition triggering, 0 selects level triggering |
| pol_high_i | input | 1 | 1 selects high level or rising edge, 0 selects low level or falling edge |
| ack_i | input | 1 | Controller vectored to this source (one-cycle pulse) |
| sw_clr_i | input | 1 | Software write-clear of the request flag |
| req_o | output | 1 | Interrupt request flag to the controller |

## Verification
Every cycle, the assertions check that the flag holds in transition mode without a clear, and that a clear wins only when no edge coincides with it. They also check that a detected edge always sets the flag, and that level mode ignores clears while the pin is active. Only the bench scenarios show the three-edge latency from the pin, the rejection of the non-selected edge direction, the absence of re-triggering on a steady pin after acknowledge, and the lag of one edge when switching mode or polarity.

// File: rtl/ext_irq_detect.sv
module ext_irq_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic trig_edge_i,
  input  logic pol_high_i,
  input  logic ack_i,
  input  logic sw_clr_i,
  output logic req_o
);

  logic meta_q, sync_q, prev_q, flag_q;
  logic rise, fall, edge_hit, lvl_active, clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise       = sync_q & ~prev_q;
  assign fall       = ~sync_q & prev_q;
  assign edge_hit   = trig_edge_i & (pol_high_i ? rise : fall);
  assign lvl_active = pol_high_i ? sync_q : ~sync_q;
  assign clr        = ack_i | sw_clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (!trig_edge_i)
      flag_q <= lvl_active;
    else
      flag_q <= edge_hit | (flag_q & ~clr);
  end

  assign req_o = flag_q;

  // R3
  hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_edge_i && req_o && !ack_i && !sw_clr_i |=> req_o);

  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_edge_i && ack_i && !(sync_q != prev_q) |=> !req_o);

  // R7
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_edge_i && (pol_high_i ? (sync_q && !prev_q) : (!sync_q && prev_q)) |=> req_o);

  // R9
  lvl_ignore_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_edge_i && (ack_i || sw_clr_i) && (sync_q == pol_high_i) |=> req_o);

endmodule

// File: tb/sim_ext_irq_detect.sv
module sim_ext_irq_detect;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pin = 1'b0, edge_m = 1'b1, pol = 1'b1, ack = 1'b0, clr = 1'b0;
  logic req;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { bit care; logic exp; string tag; } item_t;
  item_t q[$];

  ext_irq_detect u0 (.clk(clk), .rst_n(rst_n), .pin_i(pin), .trig_edge_i(edge_m),
    .pol_high_i(pol), .ack_i(ack), .sw_clr_i(clr), .req_o(req));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (it.care) begin
        checks++;
        if (req !== it.exp) begin
          errors++;
          $display("FAIL %s: req_o=%b expected %b", it.tag, req, it.exp);
        end
      end
    end
  end

  task automatic cyc(input logic p, input logic e, input logic pl, input logic a,
                     input logic c, input logic x, input string tag);
    item_t it;
    @(negedge clk);
    pin = p; edge_m = e; pol = pl; ack = a; clr = c;
    it.care = 1; it.exp = x; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin
    #20000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (req !== 1'b0) begin errors++; $display("FAIL R1: req_o=%b expected 0 in reset", req); end
    rst_n = 1'b1;
    cyc(0,1,1,0,0,0,"R1"); cyc(0,1,1,0,0,0,"R1");
    // R2 rising edge, three-edge latency
    cyc(1,1,1,0,0,0,"R2"); cyc(1,1,1,0,0,0,"R2"); cyc(1,1,1,0,0,1,"R2");
    // R3 held
    repeat (3) cyc(1,1,1,0,0,1,"R3");
    // R4 ack clears, steady pin no retrigger
    cyc(1,1,1,1,0,0,"R4"); cyc(1,1,1,0,0,0,"R4");
    // R2 falling edge ignored in rising mode
    repeat (4) cyc(0,1,1,0,0,0,"R2");
    // R5 falling mode
    repeat (2) cyc(0,1,0,0,0,0,"R5");
    repeat (4) cyc(1,1,0,0,0,0,"R5");
    cyc(0,1,0,0,0,0,"R5"); cyc(0,1,0,0,0,0,"R5"); cyc(0,1,0,0,0,1,"R5"); cyc(0,1,0,0,0,1,"R3");
    // R6 software clear
    cyc(0,1,0,0,1,0,"R6"); cyc(0,1,0,0,0,0,"R6");
    // R7 edge coinciding with ack
    repeat (2) cyc(0,1,1,0,0,0,"R2");
    cyc(1,1,1,0,0,0,"R2"); cyc(1,1,1,0,0,0,"R2"); cyc(1,1,1,0,0,1,"R2");
    repeat (3) cyc(0,1,1,0,0,1,"R3");
    cyc(1,1,1,0,0,1,"R3"); cyc(1,1,1,0,0,1,"R3"); cyc(1,1,1,1,0,1,"R7");
    cyc(1,1,1,0,0,1,"R7"); cyc(1,1,1,1,0,0,"R4");
    // R7 edge coinciding with software clear
    repeat (3) cyc(0,1,1,0,0,0,"R2");
    cyc(1,1,1,0,0,0,"R2"); cyc(1,1,1,0,0,0,"R2"); cyc(1,1,1,0,1,1,"R7");
    cyc(1,1,1,0,0,1,"R7"); cyc(1,1,1,0,1,0,"R6");
    // R8 level mode, active high
    cyc(1,0,1,0,0,1,"R8");
    cyc(1,0,1,1,0,1,"R9"); cyc(1,0,1,0,1,1,"R9"); cyc(1,0,1,1,1,1,"R9");
    cyc(0,0,1,0,0,1,"R8"); cyc(0,0,1,0,0,1,"R8"); cyc(0,0,1,0,0,0,"R8");
    cyc(0,0,1,0,0,0,"R8");
    // R8 level mode, active low
    cyc(0,0,0,0,0,1,"R8"); cyc(0,0,0,0,1,1,"R9");
    cyc(1,0,0,0,0,1,"R8"); cyc(1,0,0,0,0,1,"R8"); cyc(1,0,0,0,0,0,"R8");
    cyc(1,0,0,0,0,0,"R8");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule